// File: doc/BRIEF.md
# Byte-wide SPI port with register access

This block is a byte-wide SPI port that software reaches through three registers on a simple bus: a control register, a status register and a data register. The shift register behind the port can only be reached through the data register. Writing the data register loads the shift register and, in master mode, starts a transfer. Reading the data register returns the byte received last. Each transfer sends and receives at the same time, so every byte written is swapped for a byte received. When a transfer completes, the received byte lands in the data register, a full flag is set and an interrupt pulses for one cycle.

The port runs as a master or as a slave. As a master it makes SCK from the system clock. As a slave it takes SCK and a slave-select from outside and brings both into the system clock domain before it looks for edges. A write to the data register while a byte is still shifting sets a collision flag. That write is dropped and the byte in flight is not disturbed.

Top module: `spi_port`

## Requirements
- R1: Register map by `bus_addr`. Address 0 is control, read and written as a whole byte: bit 7 enable, bit 4 clock polarity, bits 3:0 mode, bits 6:5 spare. Address 1 is status: bit 0 full, bit 1 collision. Any write to address 1 clears the collision flag. Address 2 is data. All registers read 0 after reset.
- R2: Mode 00xx with enable set is master mode. A write to data starts an 8-bit exchange, MSB first. Between bytes `sck_out` rests at the polarity bit.
- R3: When a byte completes, the received byte goes into the data register, the full flag is set and `irq` is high for exactly one cycle.
- R4: A read strobe on address 2 clears the full flag, unless a byte completes in the same cycle.
- R5: In master mode, mode bits 1:0 choose SCK = clk/4 (00), clk/16 (01) or clk/64 (10 or 11). `irq` is seen exactly 8×divisor clock cycles after the edge that takes the data write.
- R6: A data write while a byte is in flight sets the collision flag. The write is ignored, and the bytes exchanged on both sides are those of the transfer already running.
- R7: The input is sampled on the SCK edge that leaves the idle level. The output moves to the next bit on the edge that returns to idle. The first bit appears on `sdo` as soon as the data register is written.
- R8: Mode 010x with enable set is slave mode. SCK and SDI come from outside through two-flop synchronizers, and a byte completes on the eighth edge that returns to idle. The system clock must run at least 4× the SCK rate.
- R9: In slave mode, while `ss_n` is high the bit counter is held at zero, a partly shifted byte is dropped without `irq`, and `sdo_oe` is low.
- R10: Clearing enable stops a transfer at once. `sck_out` returns to idle, no `irq` follows, and the status flags are kept.
- R11: Mode values 011x and 1xxx leave the port idle. Data writes start nothing, no `irq` is raised and `sck_out` stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears full on data reads) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq | output | 1 | One-cycle pulse when a byte completes |
| sck_out | output | 1 | SCK driven in master mode |
| sck_in | input | 1 | SCK received in slave mode |
| ss_n | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
The assertions assume that in slave mode an outside master leaves at least two system clocks between SCK edges. They also assume it holds SDI steady for more than the synchronizer delay around each edge that leaves idle. Slave-mode stimulus drives each SCK half period for 8 system clocks. SDI and `ss_n` change only at SCK edges that return to idle, and the slave is reselected only after several idle cycles. In master mode the bench plays the remote slave. It moves its SDI only after an edge that returns to idle, so the value has settled well before the next sampling tick.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              sck_out,
  input  logic              sck_in,
  input  logic              ss_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] ctrl_q, sr, rxbuf;
  logic              full, wcol, busy, samp, ph;
  logic [CNT_W-1:0]  bitcnt;
  logic [5:0]        divcnt;
  logic [2:0]        sck_sy;
  logic [1:0]        sdi_sy, ss_sy;

  wire       en        = ctrl_q[7];
  wire       cpol      = ctrl_q[4];
  wire [3:0] mode      = ctrl_q[3:0];
  wire       is_master = en && (mode[3:2] == 2'b00);
  wire       is_slave  = en && (mode[3:1] == 3'b010);
  wire       active    = is_master || is_slave;
  wire       ss_hi     = ss_sy[1];

  wire data_wr = bus_wr && (bus_addr == 2'd2);
  wire data_rd = bus_rd && (bus_addr == 2'd2);
  wire stat_wr = bus_wr && (bus_addr == 2'd1);
  wire ctrl_wr = bus_wr && (bus_addr == 2'd0);

  wire [5:0] half_m1 = (mode[1:0] == 2'b00) ? 6'd1 :
                       (mode[1:0] == 2'b01) ? 6'd7 : 6'd31;
  wire tick = is_master && busy && (divcnt == half_m1);

  wire s_lvl   = sck_sy[1] ^ cpol;
  wire s_prev  = sck_sy[2] ^ cpol;
  wire s_lead  = is_slave && !ss_hi && s_lvl && !s_prev;
  wire s_trail = is_slave && !ss_hi && !s_lvl && s_prev && busy;

  wire lead    = (tick && !ph) || s_lead;
  wire trail   = (tick && ph) || s_trail;
  wire done    = trail && (bitcnt == LAST_BIT);
  wire collide = data_wr && busy;
  wire load    = data_wr && !busy && active;
  wire samp_in = is_master ? sdi : sdi_sy[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      sdi_sy <= '0;
      ss_sy  <= 2'b11;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_in};
      sdi_sy <= {sdi_sy[0], sdi};
      ss_sy  <= {ss_sy[0], ss_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rxbuf  <= '0;
      full   <= 1'b0;
      wcol   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata;
      if (done) rxbuf <= {sr[DATA_W-2:0], samp};
      if (done) full <= 1'b1;
      else if (data_rd) full <= 1'b0;
      if (collide) wcol <= 1'b1;
      else if (stat_wr) wcol <= 1'b0;
      irq <= done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      samp   <= 1'b0;
      busy   <= 1'b0;
      bitcnt <= '0;
      ph     <= 1'b0;
      divcnt <= '0;
    end else begin
      if (load) sr <= bus_wdata;
      else if (trail) sr <= {sr[DATA_W-2:0], samp};
      if (lead) samp <= samp_in;

      if (!active || (is_slave && ss_hi)) begin
        busy   <= 1'b0;
        bitcnt <= '0;
      end else begin
        if (done) busy <= 1'b0;
        else if ((load && is_master) || s_lead) busy <= 1'b1;
        if (trail) bitcnt <= done ? '0 : bitcnt + 1'b1;
      end

      if (!is_master || !busy) begin
        divcnt <= '0;
        ph     <= 1'b0;
      end else if (tick) begin
        divcnt <= '0;
        ph     <= ~ph;
      end else begin
        divcnt <= divcnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = ctrl_q;
      2'd1:    bus_rdata = {{(DATA_W-2){1'b0}}, wcol, full};
      2'd2:    bus_rdata = rxbuf;
      default: bus_rdata = '0;
    endcase
  end

  assign sck_out = (is_master && ph) ^ cpol;
  assign sdo     = sr[DATA_W-1];
  assign sdo_oe  = is_master || (is_slave && !ss_hi);

  a_r3_irq_with_full: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> full);
  a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !done) |=> !full);
  a_r6_wcol_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(collide));
  a_r6_shift_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !trail) |=> $stable(sr));
  a_r2_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !busy) |-> (sck_out == cpol));
  a_r9_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slave && ss_hi) |-> !sdo_oe);
  a_r10_off_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !irq);
endmodule

// File: tb/spi_port_test.sv
`timescale 1ns/1ps
module spi_port_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, sck_out, sdo, sdo_oe, sdi;
  logic       s_sck = 1'b0, s_sdi = 1'b0, ss_n = 1'b1;

  logic       mdl_on = 1'b0, mcpol = 1'b0, prev_sck = 1'b0;
  logic [7:0] mtx = 8'd0, mrx = 8'd0;
  int         total = 0, bad = 0, irq_cnt = 0;

  always #2.5 clk = ~clk;

  assign sdi = mdl_on ? mtx[7] : s_sdi;

  spi_port #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck_out(sck_out), .sck_in(s_sck), .ss_n(ss_n),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (mdl_on && (sck_out !== prev_sck)) begin
      if (sck_out != mcpol) mrx = {mrx[6:0], sdo};
      else mtx = {mtx[6:0], 1'b0};
    end
    prev_sck = sck_out;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic int exp_cycles(input logic [1:0] sel);
    return 8 * ((sel == 2'b00) ? 4 : (sel == 2'b01) ? 16 : 64);
  endfunction

  task automatic config_port(input logic cp, input logic [3:0] md);
    wr(2'd0, {1'b0, 2'b00, cp, md});
    wr(2'd0, {1'b1, 2'b00, cp, md});
  endtask

  task automatic wait_irq(output int n, input int lim);
    n = 0;
    while (!irq && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic master_xfer(input logic cp, input logic [1:0] dv,
                             input logic [7:0] txb, input logic [7:0] remote);
    int n, c0;
    logic [7:0] v;
    config_port(cp, {2'b00, dv});
    @(negedge clk);
    mcpol = cp; prev_sck = sck_out; mtx = remote; mrx = 8'd0; mdl_on = 1'b1;
    chk("R2 sck idle at polarity", sck_out, cp);
    c0 = irq_cnt;
    wr(2'd2, txb);
    chk("R7 first bit on sdo at load", sdo, txb[7]);
    wait_irq(n, 5000);
    chk("R5 write-to-irq cycles", n, exp_cycles(dv));
    @(negedge clk);
    chk("R3 irq one pulse", irq_cnt - c0, 1);
    chk("R2 remote got byte MSB first", mrx, txb);
    peek(2'd2, v);
    chk("R3 data register holds received", v, remote);
    peek(2'd1, v);
    chk("R3 full set", v[0], 1'b1);
    chk("R2 sck back at idle", sck_out, cp);
    mdl_on = 1'b0;
  endtask

  task automatic slave_xfer(input logic cp, input logic [7:0] pre,
                            input logic [7:0] mb, input int nbits,
                            output logic [7:0] got);
    got = 8'd0;
    s_sck = cp;
    config_port(cp, 4'b0100);
    repeat (4) @(negedge clk);
    wr(2'd2, pre);
    repeat (4) @(negedge clk);
    ss_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      s_sdi = mb[7-i];
      repeat (8) @(negedge clk);
      got[7-i] = sdo;
      s_sck = ~cp;
      repeat (8) @(negedge clk);
      s_sck = cp;
    end
    repeat (8) @(negedge clk);
    ss_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #900000;
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, g;
    int n, c0;
    n = $urandom(32'h5eed);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    peek(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
    peek(2'd1, v); chk("R1 status reset", v, 8'h00);
    peek(2'd2, v); chk("R1 data reset", v, 8'h00);
    chk("R1 irq low after reset", irq, 1'b0);
    chk("R1 sdo_oe low after reset", sdo_oe, 1'b0);

    wr(2'd0, 8'h72);
    peek(2'd0, v); chk("R1 ctrl readback", v, 8'h72);

    // R11: unsupported mode stays idle
    config_port(1'b0, 4'b0110);
    c0 = irq_cnt;
    wr(2'd2, 8'hC3);
    repeat (300) @(negedge clk);
    chk("R11 no irq in reserved mode", irq_cnt - c0, 0);
    chk("R11 sck idle in reserved mode", sck_out, 1'b0);
    peek(2'd1, v); chk("R11 full stays clear", v[0], 1'b0);

    master_xfer(1'b0, 2'b00, 8'hA5, 8'h3C);
    master_xfer(1'b0, 2'b01, 8'h81, 8'h7E);
    master_xfer(1'b1, 2'b10, 8'h12, 8'hED);
    master_xfer(1'b1, 2'b11, 8'hFF, 8'h00);

    // R4: read of data clears full
    peek(2'd1, v); chk("R4 full before read", v[0], 1'b1);
    rd(2'd2, v);
    peek(2'd1, v); chk("R4 full cleared by data read", v[0], 1'b0);

    // R6: collision
    config_port(1'b0, 4'b0010);
    @(negedge clk);
    mcpol = 1'b0; prev_sck = sck_out; mtx = 8'h96; mrx = 8'd0; mdl_on = 1'b1;
    wr(2'd2, 8'hC7);
    repeat (100) @(negedge clk);
    wr(2'd2, 8'h5A);
    peek(2'd1, v); chk("R6 collision flag set", v[1], 1'b1);
    wait_irq(n, 5000);
    @(negedge clk);
    chk("R6 remote got original byte", mrx, 8'hC7);
    peek(2'd2, v); chk("R6 received byte intact", v, 8'h96);
    mdl_on = 1'b0;
    wr(2'd1, 8'h00);
    peek(2'd1, v); chk("R1 status write clears collision", v[1], 1'b0);

    // R10: disable mid-transfer
    rd(2'd2, v);
    config_port(1'b1, 4'b0001);
    wr(2'd2, 8'h44);
    repeat (50) @(negedge clk);
    c0 = irq_cnt;
    wr(2'd0, 8'h11);
    @(negedge clk);
    chk("R10 sck idle after disable", sck_out, 1'b1);
    repeat (600) @(negedge clk);
    chk("R10 no irq after disable", irq_cnt - c0, 0);
    peek(2'd1, v); chk("R10 full unchanged", v[0], 1'b0);
    master_xfer(1'b1, 2'b01, 8'h6B, 8'hB6);

    // R8: slave transfers
    c0 = irq_cnt;
    slave_xfer(1'b0, 8'hD2, 8'h4F, 8, g);
    chk("R8 slave sent preload", g, 8'hD2);
    peek(2'd2, v); chk("R8 slave received byte", v, 8'h4F);
    chk("R8 slave irq once", irq_cnt - c0, 1);
    c0 = irq_cnt;
    slave_xfer(1'b1, 8'h39, 8'hA0, 8, g);
    chk("R8 slave cpol1 sent", g, 8'h39);
    peek(2'd2, v); chk("R8 slave cpol1 received", v, 8'hA0);
    chk("R8 slave cpol1 irq", irq_cnt - c0, 1);

    // R9: partial byte dropped, output disabled while deselected
    chk("R9 sdo_oe low while deselected", sdo_oe, 1'b0);
    c0 = irq_cnt;
    slave_xfer(1'b0, 8'h00, 8'hF0, 3, g);
    chk("R9 no irq on partial byte", irq_cnt - c0, 0);
    slave_xfer(1'b0, 8'h5C, 8'h1E, 8, g);
    peek(2'd2, v); chk("R9 counter restarted after deselect", v, 8'h1E);
    chk("R9 sent after restart", g, 8'h5C);

    // random master and slave exchanges
    for (int k = 0; k < 12; k++) begin
      logic [7:0] a, b;
      a = 8'($urandom); b = 8'($urandom);
      master_xfer(1'($urandom), 2'($urandom_range(0, 2)), a, b);
    end
    for (int k = 0; k < 6; k++) begin
      logic [7:0] a, b;
      logic cp;
      a = 8'($urandom); b = 8'($urandom); cp = 1'($urandom);
      slave_xfer(cp, a, b, 8, g);
      chk("R8 random slave sent", g, a);
      peek(2'd2, v); chk("R8 random slave received", v, b);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule